// File: doc/BRIEF.md
# DMA Falling-Edge Request Qualifier

This block sits between one DMA channel's external request pin and the channel's transfer engine. The pin is active low. In edge mode the block turns each falling edge on the pin into exactly one pending request. A low sample taken while the channel is accepting sets a request that stays set until the engine reports that it has started the transfer. At that point the request drops and acceptance closes. Acceptance reopens only when two things have both happened: the pin has been seen high, and the engine has reported the end of its single transfer cycle. The two may happen in either order.

In level mode the pending request simply follows the low level of the pin, and there is no re-arm phase. Software configures the channel with a single write strobe that carries an enable bit and a mode bit. Every such write restarts the sequence. The pin passes through a synchronizer chain before any decision uses it, so the sampled value is always a fixed number of cycles behind the pin.

Top module: `dma_req_edge_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `req_pending` and `accept_en` are both 0.
- R2: A `cfg_wr` pulse with `cfg_en`=1 and `cfg_edge`=1 (1 selects edge mode, 0 selects level mode) clears `req_pending` and raises `accept_en` at the clock edge that ends the write cycle. The pin is sampled from the next edge onward. A pin value present in cycle k is used by the decision logic at the edge that ends cycle k+2, with the default two-stage synchronizer.
- R3: In edge mode, a low sample taken while `accept_en` is 1 sets `req_pending` and clears `accept_en`. The request stays set even if the pin returns high.
- R4: In edge mode, `act_start` while a request is held clears `req_pending`, and `accept_en` stays 0. `act_start` and `cycle_end` have no effect while the block is accepting.
- R5: After activation, `accept_en` returns to 1 only once both a high sample and a `cycle_end` pulse have been seen since activation. If the high sample comes first, re-arming waits for `cycle_end`. If `cycle_end` comes first, re-arming waits for the high sample.
- R6: If the pin stays low through and after the transfer cycle, no second request is raised until a high sample has been taken.
- R7: In level mode, `req_pending` equals the inverse of the synchronized pin while the channel is enabled, `accept_en` equals the enable bit, and `act_start` has no effect.
- R8: A `cfg_wr` with `cfg_en`=0 clears `req_pending` and `accept_en` at the next edge, from any state. Both stay 0 until the channel is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | One-cycle configuration write strobe |
| cfg_en | input | 1 | Channel enable value loaded by `cfg_wr` |
| cfg_edge | input | 1 | Mode value loaded by `cfg_wr`: 1 edge, 0 level |
| req_pin_n | input | 1 | External request pin, active low, asynchronous |
| act_start | input | 1 | Engine pulse: transfer activation has started |
| cycle_end | input | 1 | Engine pulse: the single transfer cycle has ended |
| req_pending | output | 1 | Request held toward the engine |
| accept_en | output | 1 | High while a new pin request can be accepted |

## Verification
A short low pulse on the pin checks that the request is held after the pin returns high, and that it clears only on activation. Two re-arm orderings are driven: high sample before cycle end, and cycle end before high sample. Together they distinguish a design that needs both conditions from one that needs either. A pin held low across a whole transfer separates a true edge qualifier from a level follower. The same low level, driven in level mode and through a disable issued mid-request, shows that the mode bit and the enable bit each change the outcome.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

   // Edge-mode sequencer states
   typedef enum logic [1:0] {
      QST_IDLE   = 2'd0,  // channel off or level mode
      QST_ACCEPT = 2'd1,  // waiting for a low sample
      QST_HELD   = 2'd2,  // request pending toward engine
      QST_REARM  = 2'd3   // activated; waiting for high sample and cycle end
   } qual_state_e;

   localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   import dma_req_pkg::*;

   if (STAGES < MIN_SYNC_STAGES) begin : g_bad_stages
      $error("dma_req_sync: STAGES must be at least %0d", MIN_SYNC_STAGES);
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= RESET_VAL;
            else        chain_q[0] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= RESET_VAL;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/dma_req_edge_fsm.sv
module dma_req_edge_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,       // configuration write this cycle
   input  logic restart_arm,   // write enables channel in edge mode
   input  logic active,        // channel enabled and in edge mode
   input  logic pin_lo,        // synchronized pin sampled low
   input  logic act_start,
   input  logic cycle_end,
   output logic pending,
   output logic accepting
);
   import dma_req_pkg::*;

   qual_state_e state_q, state_d;
   logic        hi_seen_q, hi_seen_d;
   logic        end_seen_q, end_seen_d;
   logic        hi_now, end_now;

   assign hi_now  = hi_seen_q | ~pin_lo;
   assign end_now = end_seen_q | cycle_end;

   always_comb begin
      state_d    = state_q;
      hi_seen_d  = hi_seen_q;
      end_seen_d = end_seen_q;
      if (restart) begin
         state_d    = restart_arm ? QST_ACCEPT : QST_IDLE;
         hi_seen_d  = 1'b0;
         end_seen_d = 1'b0;
      end else if (!active) begin
         state_d    = QST_IDLE;
         hi_seen_d  = 1'b0;
         end_seen_d = 1'b0;
      end else begin
         unique case (state_q)
            QST_IDLE:   state_d = QST_IDLE;
            QST_ACCEPT: if (pin_lo) state_d = QST_HELD;
            QST_HELD: begin
               if (act_start) begin
                  state_d    = QST_REARM;
                  hi_seen_d  = 1'b0;
                  end_seen_d = 1'b0;
               end
            end
            QST_REARM: begin
               if (hi_now && end_now) begin
                  state_d    = QST_ACCEPT;
                  hi_seen_d  = 1'b0;
                  end_seen_d = 1'b0;
               end else begin
                  hi_seen_d  = hi_now;
                  end_seen_d = end_now;
               end
            end
            default: state_d = QST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= QST_IDLE;
         hi_seen_q  <= 1'b0;
         end_seen_q <= 1'b0;
      end else begin
         state_q    <= state_d;
         hi_seen_q  <= hi_seen_d;
         end_seen_q <= end_seen_d;
      end
   end

   assign pending   = (state_q == QST_HELD);
   assign accepting = (state_q == QST_ACCEPT);

endmodule

// File: rtl/dma_req_level_path.sv
module dma_req_level_path (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic active,   // channel enabled and in level mode
   input  logic pin_lo,
   output logic pending
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pending <= 1'b0;
      else if (restart) pending <= 1'b0;
      else              pending <= active & pin_lo;
   end

endmodule

// File: rtl/dma_req_edge_ctrl.sv
module dma_req_edge_ctrl #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic        PIN_IDLE    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_wr,
   input  logic cfg_en,
   input  logic cfg_edge,
   input  logic req_pin_n,
   input  logic act_start,
   input  logic cycle_end,
   output logic req_pending,
   output logic accept_en
);

   logic en_q, edge_q;
   logic pin_sync, pin_lo;
   logic edge_active, level_active;
   logic edge_pend, edge_acc, level_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         edge_q <= 1'b1;
      end else if (cfg_wr) begin
         en_q   <= cfg_en;
         edge_q <= cfg_edge;
      end
   end

   dma_req_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (PIN_IDLE)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (req_pin_n),
      .q_sync  (pin_sync)
   );

   assign pin_lo       = ~pin_sync;
   assign edge_active  = en_q & edge_q;
   assign level_active = en_q & ~edge_q;

   dma_req_edge_fsm u_edge (
      .clk         (clk),
      .rst_n       (rst_n),
      .restart     (cfg_wr),
      .restart_arm (cfg_en & cfg_edge),
      .active      (edge_active),
      .pin_lo      (pin_lo),
      .act_start   (act_start),
      .cycle_end   (cycle_end),
      .pending     (edge_pend),
      .accepting   (edge_acc)
   );

   dma_req_level_path u_level (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (cfg_wr),
      .active  (level_active),
      .pin_lo  (pin_lo),
      .pending (level_pend)
   );

   assign req_pending = edge_q ? edge_pend : level_pend;
   assign accept_en   = edge_q ? edge_acc  : en_q;

endmodule

// File: rtl/dma_req_edge_chk.sv
module dma_req_edge_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_wr,
   input logic cfg_en,
   input logic act_start,
   input logic edge_mode,
   input logic req_pending,
   input logic accept_en
);

   // R3: a held request persists until activation or reconfiguration
   a_r3_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      edge_mode && req_pending && !act_start && !cfg_wr |=> req_pending);

   // R3: a held request and open acceptance never coexist in edge mode
   a_r3_held_blocks_accept: assert property (@(posedge clk) disable iff (!rst_n)
      edge_mode |-> !(req_pending && accept_en));

   // R4: activation drops the request and keeps acceptance closed
   a_r4_act_clears: assert property (@(posedge clk) disable iff (!rst_n)
      edge_mode && req_pending && act_start && !cfg_wr |=> !req_pending && !accept_en);

   // R8: a disabling write clears both outputs
   a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr && !cfg_en |=> !req_pending && !accept_en);

   // R3: in edge mode a new request only arises from an accepting state
   a_r3_rise_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
      edge_mode && $rose(req_pending) |-> $past(accept_en));

endmodule

bind dma_req_edge_ctrl dma_req_edge_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_wr      (cfg_wr),
   .cfg_en      (cfg_en),
   .act_start   (act_start),
   .edge_mode   (edge_q),
   .req_pending (req_pending),
   .accept_en   (accept_en)
);

// File: tb/dma_req_edge_ctrl_test.sv
module dma_req_edge_ctrl_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr = 1'b0, cfg_en = 1'b0, cfg_edge = 1'b0;
   logic req_pin_n = 1'b1, act_start = 1'b0, cycle_end = 1'b0;
   logic req_pending, accept_en;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   dma_req_edge_ctrl uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
      .cfg_edge(cfg_edge), .req_pin_n(req_pin_n), .act_start(act_start),
      .cycle_end(cycle_end), .req_pending(req_pending), .accept_en(accept_en)
   );

   // {wr, en, edge, pin_n, act, end, exp_pend, exp_acc}
   localparam int NVEC = 38;
   localparam logic [7:0] VEC [NVEC] = '{
      8'b1_1_1_1_0_0_0_1, // 0  R2 enable edge mode
      8'b0_0_0_0_0_0_0_1, // 1  pin low
      8'b0_0_0_0_0_0_0_1, // 2
      8'b0_0_0_1_0_0_1_0, // 3  R3 request set, pin back high
      8'b0_0_0_1_0_0_1_0, // 4  R3 held
      8'b0_0_0_1_1_0_0_0, // 5  R4 activation
      8'b0_0_0_1_0_0_0_0, // 6  R5 high seen, no end yet
      8'b0_0_0_1_0_1_0_1, // 7  R5 end arrives -> re-arm
      8'b0_0_0_0_0_0_0_1, // 8  second falling edge
      8'b0_0_0_0_0_0_0_1, // 9
      8'b0_0_0_0_0_0_1_0, // 10 R3 second request
      8'b0_0_0_0_1_0_0_0, // 11 R4 activation, pin still low
      8'b0_0_0_0_0_1_0_0, // 12 R5 end before high
      8'b0_0_0_0_0_0_0_0, // 13 R6 no second request
      8'b0_0_0_1_0_0_0_0, // 14 R6
      8'b0_0_0_1_0_0_0_0, // 15 R6
      8'b0_0_0_1_0_0_0_1, // 16 R5 high sample completes re-arm
      8'b0_0_0_1_1_1_0_1, // 17 R4 act/end ignored while accepting
      8'b1_1_0_1_0_0_0_1, // 18 R7 level mode
      8'b0_0_0_0_0_0_0_1, // 19
      8'b0_0_0_0_0_0_0_1, // 20
      8'b0_0_0_1_0_0_1_1, // 21 R7 follows low
      8'b0_0_0_1_1_0_1_1, // 22 R7 act ignored
      8'b0_0_0_1_0_0_0_1, // 23 R7 follows high
      8'b1_0_0_0_0_0_0_0, // 24 R8 disable
      8'b0_0_0_0_0_0_0_0, // 25 R8 pin low ignored
      8'b0_0_0_0_0_0_0_0, // 26 R8
      8'b1_1_1_0_0_0_0_1, // 27 R2 enable with pin already low
      8'b0_0_0_0_0_0_1_0, // 28 R2 first sample next edge
      8'b0_0_0_0_1_0_0_0, // 29 R4
      8'b0_0_0_1_0_1_0_0, // 30 R5 end first
      8'b0_0_0_1_0_0_0_0, // 31 R5 waiting high sample
      8'b0_0_0_1_0_0_0_1, // 32 R5 re-armed
      8'b0_0_0_0_0_0_0_1, // 33
      8'b0_0_0_0_0_0_0_1, // 34
      8'b0_0_0_0_0_0_1_0, // 35 R3
      8'b1_0_0_0_0_0_0_0, // 36 R8 disable while held
      8'b0_0_0_1_0_0_0_0  // 37 R8 stays clear
   };

   task automatic check(input string req, input logic act_p, input logic act_a,
                        input logic exp_p, input logic exp_a);
      total++;
      if (act_p !== exp_p || act_a !== exp_a) begin
         bad++;
         $display("FAIL %s: pend/acc actual=%b%b expected=%b%b", req, act_p, act_a, exp_p, exp_a);
      end
   endtask

   initial begin
      #(4 * 200000);
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", req_pending, accept_en, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", req_pending, accept_en, 1'b0, 1'b0);

      for (int i = 0; i < NVEC; i++) begin
         {cfg_wr, cfg_en, cfg_edge, req_pin_n, act_start, cycle_end} = VEC[i][7:2];
         @(negedge clk);
         check($sformatf("row %0d", i), req_pending, accept_en, VEC[i][1], VEC[i][0]);
      end
      {cfg_wr, cfg_en, cfg_edge, act_start, cycle_end} = '0;

      // R1: reset mid-request returns to the cleared state
      {cfg_wr, cfg_en, cfg_edge} = 3'b111;
      req_pin_n = 1'b0;
      @(negedge clk);
      cfg_wr = 1'b0;
      repeat (3) @(negedge clk);
      check("R3 pre-reset", req_pending, accept_en, 1'b1, 1'b0);
      rst_n = 1'b0;
      #1;
      check("R1 async", req_pending, accept_en, 1'b0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", req_pending, accept_en, 1'b0, 1'b0);

      // R5: high sample and cycle end in the same cycle re-arm at once
      req_pin_n = 1'b1;
      {cfg_wr, cfg_en, cfg_edge} = 3'b111;
      @(negedge clk);
      cfg_wr = 1'b0;
      req_pin_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R3", req_pending, accept_en, 1'b1, 1'b0);
      req_pin_n = 1'b1;
      act_start = 1'b1;
      @(negedge clk);
      act_start = 1'b0;
      @(negedge clk);
      cycle_end = 1'b1;
      @(negedge clk);
      cycle_end = 1'b0;
      check("R5 both same cycle", req_pending, accept_en, 1'b0, 1'b1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule